// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wraparound

This block sits behind a serial memory command decoder and handles the data phase of a write command. When a command opens, it takes a start address and works out which page that address belongs to. It then stores each incoming data byte into a page-sized latch. Each stored byte advances a write offset. When the offset passes the last byte of the page it returns to the first byte of the same page, so later bytes overwrite earlier ones. A per-slot valid mask records which latch slots the current command has loaded. The mask is cleared whenever a new command opens.

When the command ends, the decoder presents a commit request together with a flag saying whether the command ended exactly on a byte boundary. A commit that is byte-aligned and has at least one loaded byte starts a self-timed write cycle. The cycle lasts `WRITE_CYCLES` clocks, and `busy` is high throughout. On the last cycle, only the masked slots are copied into the matching addresses of the page in a plain byte-array memory. While the cycle runs, new commands, data bytes, commits and reads are all ignored. `PAGE_BYTES` is 16, 32 or 64. `MEM_BYTES` is a power of two and at least twice the page size.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and every memory byte reads as 0x00.
- R2: A commit accepted at a clock edge makes `busy` go high from the next cycle, and `busy` stays high for exactly `WRITE_CYCLES` cycles. A commit is accepted only when `commit_req` is high, `end_aligned` is high, a command is open and at least one byte has been loaded.
- R3: After `busy` falls, the k-th data byte of the command (k counting from 0) is stored at page_base + ((start_offset + k) mod `PAGE_BYTES`). Here page_base is the start address rounded down to a multiple of `PAGE_BYTES`, and start_offset is the start address minus page_base.
- R4: When a command supplies more than `PAGE_BYTES` bytes, the offset wraps within the same page, and the byte loaded last into a slot is the one stored.
- R5: Page locations that the command did not load keep their previous contents.
- R6: A `commit_req` with `end_aligned` low does not raise `busy`, and the memory is left unchanged.
- R7: While `busy` is high, `cmd_start`, `byte_valid` and `commit_req` are ignored. The running cycle completes with its original data, and no second write follows.
- R8: A read requested with `rd_en` while `busy` is low returns `rd_valid`=1 and the addressed byte on the next cycle. A read requested while `busy` is high returns `rd_valid`=0.
- R9: Opening a new command clears the valid mask, so bytes loaded by an earlier dropped command are not written by a later commit.
- R10: A commit with no byte loaded since the command opened, or with no command open, does not raise `busy`.
- R11: A commit writes no address outside the page that holds the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Opens a write command at `start_addr` |
| start_addr | input | ADDR_W | First byte address of the command |
| byte_valid | input | 1 | Strobe for one data byte |
| byte_data | input | 8 | Data byte |
| commit_req | input | 1 | End of command (chip-select rise) |
| end_aligned | input | 1 | High when the command ended right after a whole byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read was served in the previous cycle |
| busy | output | 1 | Self-timed write cycle running |

## Verification
The bench drives inputs at falling edges and samples outputs at the next falling edge. At that point `busy` must already be high after a commit. The bench then counts the falling edges at which `busy` stays high and compares the count with `WRITE_CYCLES`. Read data is due one cycle after `rd_en`, so each readback samples at the falling edge that follows the request. New array contents are checked only once `busy` has been seen low, because the array is written on the last busy cycle. Expected memory contents come from a bench model that applies the wrapped offsets arithmetically. Every start offset is swept against short, exactly full and overflowing byte counts.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    PWB_IDLE  = 2'd0,
    PWB_LOAD  = 2'd1,
    PWB_WRITE = 2'd2
  } pwb_state_e;

  function automatic bit page_size_legal(input int unsigned pb);
    return (pb == 16) || (pb == 32) || (pb == 64);
  endfunction

  // first address of the page holding addr
  function automatic int unsigned page_base_of(input int unsigned addr, input int unsigned pb);
    return addr - (addr % pb);
  endfunction

  function automatic int unsigned page_offset_of(input int unsigned addr, input int unsigned pb);
    return addr % pb;
  endfunction

  // next latch slot, wrapping inside the page
  function automatic int unsigned wrap_next(input int unsigned off, input int unsigned pb);
    return (off + 1) % pb;
  endfunction

  function automatic bit same_page(input int unsigned a, input int unsigned b, input int unsigned pb);
    return (a / pb) == (b / pb);
  endfunction

endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        open_cmd,
  input  logic                        load_byte,
  input  logic [ADDR_W-1:0]           start_addr,
  input  logic [7:0]                  byte_data,
  output logic [ADDR_W-1:0]           page_base,
  output logic [PAGE_BYTES-1:0][7:0]  lat_data,
  output logic [PAGE_BYTES-1:0]       lat_mask,
  output logic                        mask_empty
);

  logic [OFF_W-1:0] wr_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_base <= '0;
      wr_off    <= '0;
    end else if (open_cmd) begin
      page_base <= ADDR_W'(pwb_pkg::page_base_of(32'(start_addr), PAGE_BYTES));
      wr_off    <= OFF_W'(pwb_pkg::page_offset_of(32'(start_addr), PAGE_BYTES));
    end else if (load_byte) begin
      wr_off    <= OFF_W'(pwb_pkg::wrap_next(32'(wr_off), PAGE_BYTES));
    end
  end

  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        slot_v <= 1'b0;
      end else if (open_cmd) begin
        slot_v <= 1'b0;
      end else if (load_byte && (wr_off == OFF_W'(gi))) begin
        slot_q <= byte_data;
        slot_v <= 1'b1;
      end
    end
    assign lat_data[gi] = slot_q;
    assign lat_mask[gi] = slot_v;
  end

  assign mask_empty = (lat_mask == '0);

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl #(
  parameter int WRITE_CYCLES = 64,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic byte_valid,
  input  logic commit_req,
  input  logic end_aligned,
  input  logic mask_empty,
  output logic open_cmd,
  output logic load_byte,
  output logic commit_fire,
  output logic cycle_done,
  output logic busy
);
  import pwb_pkg::*;

  pwb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             in_load;

  assign in_load     = (state_q == PWB_LOAD);
  assign busy        = (state_q == PWB_WRITE);
  assign cycle_done  = busy && (cnt_q == '0);
  assign commit_fire = in_load && commit_req && end_aligned && !mask_empty;
  assign open_cmd    = cmd_start && !busy && !(in_load && commit_req);
  assign load_byte   = byte_valid && in_load && !cmd_start && !commit_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWB_IDLE:  if (cmd_start) state_d = PWB_LOAD;
      PWB_LOAD:  if (commit_req) state_d = commit_fire ? PWB_WRITE : PWB_IDLE;
      PWB_WRITE: if (cycle_done) state_d = PWB_IDLE;
      default:   state_d = PWB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (commit_fire)
        cnt_q <= CNT_W'(WRITE_CYCLES - 1);
      else if (busy && (cnt_q != '0))
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  localparam int ADDR_W    = $clog2(MEM_BYTES),
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit_now,
  input  logic [ADDR_W-1:0]          page_base,
  input  logic [PAGE_BYTES-1:0][7:0] lat_data,
  input  logic [PAGE_BYTES-1:0]      lat_mask,
  input  logic                       rd_accept,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       rd_valid
);

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < MEM_BYTES; w++) mem[ADDR_W'(w)] <= '0;
    end else if (commit_now) begin
      for (int w = 0; w < MEM_BYTES; w++) begin
        if (lat_mask[OFF_W'(w)] &&
            pwb_pkg::same_page(w, 32'(page_base), PAGE_BYTES))
          mem[ADDR_W'(w)] <= lat_data[OFF_W'(w)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_accept;
      if (rd_accept) rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 64,
  localparam int ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              commit_req,
  input  logic              end_aligned,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy
);

  if (!pwb_pkg::page_size_legal(PAGE_BYTES)) begin : g_bad_page
    $error("PAGE_BYTES must be 16, 32 or 64");
  end

  // named internal events, observed by the bound checker
  logic                       open_cmd;
  logic                       load_byte;
  logic                       commit_fire;
  logic                       cycle_done;
  logic                       mask_empty;
  logic                       rd_accept;
  logic [ADDR_W-1:0]          page_base;
  logic [PAGE_BYTES-1:0][7:0] lat_data;
  logic [PAGE_BYTES-1:0]      lat_mask;

  assign rd_accept = rd_en && !busy;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .byte_valid (byte_valid),
    .commit_req (commit_req),
    .end_aligned(end_aligned),
    .mask_empty (mask_empty),
    .open_cmd   (open_cmd),
    .load_byte  (load_byte),
    .commit_fire(commit_fire),
    .cycle_done (cycle_done),
    .busy       (busy)
  );

  pwb_latch #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) latch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_cmd  (open_cmd),
    .load_byte (load_byte),
    .start_addr(start_addr),
    .byte_data (byte_data),
    .page_base (page_base),
    .lat_data  (lat_data),
    .lat_mask  (lat_mask),
    .mask_empty(mask_empty)
  );

  pwb_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) array_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_now(cycle_done),
    .page_base (page_base),
    .lat_data  (lat_data),
    .lat_mask  (lat_mask),
    .rd_accept (rd_accept),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int WRITE_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic commit_req,
  input logic end_aligned,
  input logic rd_en,
  input logic busy,
  input logic rd_valid,
  input logic commit_fire,
  input logic cycle_done,
  input logic mask_empty
);

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= '0;
  end

  // R2
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> busy);

  // R2
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_fire));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(WRITE_CYCLES)));

  // R2
  busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 32'(WRITE_CYCLES)));

  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !busy);

  // R6
  unaligned_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !end_aligned && !busy) |=> !busy);

  // R10
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && mask_empty && !busy) |=> !busy);

  // R7
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_fire);

  // R8
  read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> !rd_valid);

  // R8
  read_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> rd_valid);

endmodule

bind page_write_buffer page_write_buffer_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit_req (commit_req),
  .end_aligned(end_aligned),
  .rd_en      (rd_en),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .commit_fire(commit_fire),
  .cycle_done (cycle_done),
  .mask_empty (mask_empty)
);

// File: tb/page_write_buffer_tb_top.sv
module page_write_buffer_tb_top;

  localparam int MEM = 64;
  localparam int PG  = 16;
  localparam int W   = 12;
  localparam int AW  = $clog2(MEM);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          commit_req = 1'b0;
  logic          end_aligned = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          busy;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [MEM];

  always #10 clk = ~clk;

  page_write_buffer #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .WRITE_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .commit_req(commit_req),
    .end_aligned(end_aligned), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  function automatic logic [7:0] pat(input int s, input int li, input int k);
    return 8'(s * 29 + li * 71 + k * 13 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic open_at(input int a);
    @(negedge clk); cmd_start = 1'b1; start_addr = AW'(a);
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic finish_cmd(input bit aligned, input bit expect_fire, input string req);
    int cnt;
    @(negedge clk); commit_req = 1'b1; end_aligned = aligned;
    @(negedge clk); commit_req = 1'b0; end_aligned = 1'b0;
    if (expect_fire) begin
      chk(busy == 1'b1, {req, " busy rises next cycle"}, int'(busy), 1);
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
      chk(cnt == W, "R2 busy length", cnt, W);
    end else begin
      chk(busy == 1'b0, {req, " no write cycle"}, int'(busy), 0);
    end
  endtask

  task automatic read_chk(input int a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid == 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
    chk(rd_data == e, req, int'(rd_data), int'(e));
  endtask

  task automatic full_readback(input string req);
    for (int a = 0; a < MEM; a++) read_chk(a, model[a], req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < MEM; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    full_readback("R1 R8 reset contents");

    // sweep: every start offset, lengths short / partial / full page / overflow
    for (int s = 0; s < PG; s++) begin
      for (int li = 0; li < 4; li++) begin
        automatic int len  = (li == 0) ? 1 : (li == 1) ? 5 : (li == 2) ? PG : PG + 5;
        automatic int base = ((s + li) % (MEM / PG)) * PG;
        open_at(base + s);
        for (int k = 0; k < len; k++) begin
          put_byte(pat(s, li, k));
          model[base + ((s + k) % PG)] = pat(s, li, k);
        end
        finish_cmd(1'b1, 1'b1, "R2");
        if (li == 3) begin
          // R4: slot s was loaded by byte 0 and again by byte PG
          read_chk(base + s, pat(s, li, PG), "R4 wrap overwrite");
        end
        full_readback("R3 R5 R11 memory image");
      end
    end

    // R6: misaligned end drops the write
    open_at(8'h10);
    for (int k = 0; k < 4; k++) put_byte(8'hC0 + 8'(k));
    finish_cmd(1'b0, 1'b0, "R6");
    full_readback("R6 unchanged");

    // R9: new command clears the mask left by the dropped one
    open_at(8'h18);
    put_byte(8'h3C);
    model[8'h18] = 8'h3C;
    finish_cmd(1'b1, 1'b1, "R9");
    full_readback("R9 only own byte written");

    // R10: commit with nothing loaded, then commit with no command open
    open_at(8'h24);
    finish_cmd(1'b1, 1'b0, "R10 empty command");
    finish_cmd(1'b1, 1'b0, "R10 no command");
    full_readback("R10 unchanged");

    // R7 / R8: stimulus during a running write is ignored
    open_at(8'h20);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'hA1 + 8'(k));
      model[8'h20 + k] = 8'hA1 + 8'(k);
    end
    @(negedge clk); commit_req = 1'b1; end_aligned = 1'b1;
    @(negedge clk); commit_req = 1'b0; end_aligned = 1'b0;
    chk(busy == 1'b1, "R2 busy rises next cycle", int'(busy), 1);
    rd_en = 1'b1; rd_addr = AW'(8'h20);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R8 read while busy", int'(rd_valid), 0);
    cmd_start = 1'b1; start_addr = AW'(8'h05);
    @(negedge clk); cmd_start = 1'b0; byte_valid = 1'b1; byte_data = 8'h5A;
    @(negedge clk); byte_valid = 1'b0; commit_req = 1'b1; end_aligned = 1'b1;
    @(negedge clk); commit_req = 1'b0; end_aligned = 1'b0;
    chk(busy == 1'b1, "R7 write keeps running", int'(busy), 1);
    while (busy) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(busy == 1'b0, "R7 no second write", int'(busy), 0);
      @(negedge clk);
    end
    full_readback("R7 original data only");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule